// File: doc/BRIEF.md
# Byte-Lane Data Memory

A synchronous data memory made of wide rows (eight bytes per row by default) that serves loads and stores of one byte, two bytes, four bytes or a whole row. Each request names a byte address, a width code, a direction, write data and a byte-reversal option. Stores narrower than a row rewrite only the byte lanes they cover and keep the other lanes of the row. Loads pick the addressed lanes out of the row and return them starting at bit 0.

The address splits into a row index (the upper bits) and a lane offset (the bits that select a byte inside a row). An access must sit on a multiple of its own size. A request that does not is refused: it raises an error flag on the response and changes nothing. When byte reversal is chosen, the bytes are flipped over exactly the access size. A store flips them before they are written, and a load flips them after they are extracted. Rows not written since reset read as zero. Every request gets a response one clock later.

Top module: `bytemem`

## Requirements
- R1: A load returns, one clock after the request, with rsp_valid high, the bytes starting at the lane offset, right-justified. Memory byte address row*ROW_BYTES+k sits in row bits [8k+7:8k], so a full-row load returns byte k in bits [8k+7:8k]. rsp_valid is high exactly in the cycles that follow a request.
- R2: A row not stored to since reset reads as zero. After reset, rsp_valid, rsp_err and rsp_data are all zero.
- R3: Width code 00 selects 1 byte, 01 selects 2 bytes, 10 selects 4 bytes and 11 selects 8 bytes. A load of N bytes returns zero in all bits at and above bit 8N.
- R4: A store narrower than a row writes the low N bytes of req_wdata into the addressed lanes. The other lanes of the row keep their contents, and the req_wdata bits above the access width have no effect.
- R5: A full-row store (code 11) replaces the whole row with req_wdata.
- R6: A request whose lane offset is not a multiple of its size in bytes is misaligned. A request wider than a row is also misaligned. Either one raises rsp_err in the response cycle only, returns zero data and leaves memory unchanged.
- R7: A store with req_swap high writes its N bytes in reverse order. Byte N-1 of req_wdata lands at the lowest addressed lane.
- R8: A load with req_swap high returns the N extracted bytes in reverse order within the low N bytes.
- R9: A store response has rsp_valid high, rsp_err low and rsp_data zero. A load issued the next cycle already sees the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W | Byte address (row index and lane offset) |
| req_wcode | input | 2 | Access width code |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 8*ROW_BYTES | Store data, right-justified |
| req_swap | input | 1 | Reverse byte order within the access width |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Last request was misaligned |
| rsp_data | output | 8*ROW_BYTES | Load data, right-justified |

## Verification
The bound properties check the response handshake on every cycle. They also check that every misaligned request, and no aligned one, raises the error, and that an error response or a store response carries zero data. A further property checks that a narrow load never returns bits above its width. Lane placement, preservation of neighbouring lanes, byte reversal in both directions, zero reads of fresh rows and the fact that a refused store leaves memory untouched all depend on data values. The bench scoreboard shows these, by comparing every response against a byte-level model of the memory over directed and pseudo-random request streams.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [1:0] {
      BM_W1 = 2'b00,
      BM_W2 = 2'b01,
      BM_W4 = 2'b10,
      BM_W8 = 2'b11
   } bm_width_e;

   // access size in bytes for a width code
   function automatic int bm_nbytes(input logic [1:0] code);
      return 1 << code;
   endfunction
endpackage

// File: rtl/bm_lane_ctrl.sv
module bm_lane_ctrl #(
   parameter int ROW_BYTES = 8,
   parameter int IDX_W     = 4,
   localparam int OFF_W    = $clog2(ROW_BYTES),
   localparam int ADDR_W   = IDX_W + OFF_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        wcode,
   output logic [IDX_W-1:0]  row_idx,
   output logic [OFF_W-1:0]  lane_off,
   output logic [ROW_BYTES-1:0] byte_en,
   output logic              misalign
);
   int nb;

   assign nb       = bm_pkg::bm_nbytes(wcode);
   assign row_idx  = addr[ADDR_W-1:OFF_W];
   assign lane_off = addr[OFF_W-1:0];
   assign misalign = (nb > ROW_BYTES) || ((lane_off & OFF_W'(nb - 1)) != '0);

   for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lane
      assign byte_en[i] = (i >= int'(lane_off)) && (i < int'(lane_off) + nb);
   end
endmodule

// File: rtl/bm_swap.sv
module bm_swap #(
   parameter int ROW_BYTES = 8,
   localparam int ROW_W    = ROW_BYTES * 8,
   localparam int BI_W     = $clog2(ROW_BYTES)
) (
   input  logic [ROW_W-1:0] data_i,
   input  logic [1:0]       wcode,
   input  logic             en,
   output logic [ROW_W-1:0] data_o
);
   logic [7:0] in_b [ROW_BYTES];
   int nb;

   assign nb = bm_pkg::bm_nbytes(wcode);

   for (genvar i = 0; i < ROW_BYTES; i++) begin : g_byte
      assign in_b[i] = data_i[i*8 +: 8];
      always_comb begin
         data_o[i*8 +: 8] = in_b[i];
         if (en) begin
            if (i < nb) data_o[i*8 +: 8] = in_b[BI_W'(nb - 1 - i)];
            else        data_o[i*8 +: 8] = 8'h00;
         end
      end
   end
endmodule

// File: rtl/bm_row_array.sv
module bm_row_array #(
   parameter int ROW_BYTES = 8,
   parameter int DEPTH     = 16,
   localparam int ROW_W    = ROW_BYTES * 8,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ROW_W-1:0] rd_row,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ROW_W-1:0] wr_row
);
   logic [ROW_W-1:0] rows  [DEPTH];
   logic [DEPTH-1:0] written;

   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(r)) rows[r] <= wr_row;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              written[r] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(r))   written[r] <= 1'b1;
      end
   end

   // unwritten rows read back as zero
   assign rd_row = written[rd_idx] ? rows[rd_idx] : '0;
endmodule

// File: rtl/bytemem.sv
module bytemem #(
   parameter int ROW_BYTES = 8,
   parameter int DEPTH     = 16,
   localparam int ROW_W    = ROW_BYTES * 8,
   localparam int OFF_W    = $clog2(ROW_BYTES),
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int ADDR_W   = IDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_wcode,
   input  logic              req_we,
   input  logic [ROW_W-1:0]  req_wdata,
   input  logic              req_swap,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [ROW_W-1:0]  rsp_data
);
   if (ROW_BYTES < 2 || ROW_BYTES > 8 || (ROW_BYTES & (ROW_BYTES - 1)) != 0) begin : g_bad_row
      $error("ROW_BYTES must be 2, 4 or 8");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic [IDX_W-1:0]     row_idx;
   logic [OFF_W-1:0]     lane_off;
   logic [ROW_BYTES-1:0] byte_en;
   logic                 misalign;
   logic [ROW_W-1:0]     cur_row, new_row;
   logic [ROW_W-1:0]     ext_raw, ld_data, st_raw, st_data;
   logic [7:0]           row_b [ROW_BYTES];
   logic [7:0]           st_b  [ROW_BYTES];
   int                   nb;

   assign nb = bm_pkg::bm_nbytes(req_wcode);

   bm_lane_ctrl #(.ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)) u_lane (
      .addr(req_addr), .wcode(req_wcode), .row_idx(row_idx),
      .lane_off(lane_off), .byte_en(byte_en), .misalign(misalign)
   );

   bm_row_array #(.ROW_BYTES(ROW_BYTES), .DEPTH(DEPTH)) u_rows (
      .clk(clk), .rst_n(rst_n), .rd_idx(row_idx), .rd_row(cur_row),
      .wr_en(req_valid && req_we && !misalign), .wr_idx(row_idx), .wr_row(new_row)
   );

   for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lanes
      assign row_b[i] = cur_row[i*8 +: 8];
      assign st_b[i]  = st_data[i*8 +: 8];
      // load: pull lane (offset + i) down to byte i
      always_comb begin
         if (i < nb && (int'(lane_off) + i) < ROW_BYTES)
            ext_raw[i*8 +: 8] = row_b[BI_SEL'(int'(lane_off) + i)];
         else
            ext_raw[i*8 +: 8] = 8'h00;
      end
      // store: keep only the low access-width bytes of the write data
      assign st_raw[i*8 +: 8] = (i < nb) ? req_wdata[i*8 +: 8] : 8'h00;
      // merge: covered lanes take store byte (i - offset)
      assign new_row[i*8 +: 8] = byte_en[i] ? st_b[BI_SEL'(i - int'(lane_off))] : row_b[i];
   end

   localparam int BI_SEL = OFF_W;

   bm_swap #(.ROW_BYTES(ROW_BYTES)) u_ld_swap (
      .data_i(ext_raw), .wcode(req_wcode), .en(req_swap), .data_o(ld_data)
   );
   bm_swap #(.ROW_BYTES(ROW_BYTES)) u_st_swap (
      .data_i(st_raw), .wcode(req_wcode), .en(req_swap), .data_o(st_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && misalign;
         rsp_data  <= (req_valid && !req_we && !misalign) ? ld_data : '0;
      end
   end
endmodule

// File: rtl/bm_chk.sv
module bm_chk #(
   parameter int ROW_BYTES = 8,
   parameter int ADDR_W    = 7,
   localparam int ROW_W    = ROW_BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_wcode,
   input logic              req_we,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [ROW_W-1:0]  rsp_data
);
   localparam int OFF_W = $clog2(ROW_BYTES);

   logic             bad_req;
   logic [ROW_W-1:0] fit_mask, fit_mask_q;
   int               nbytes;

   assign nbytes  = 1 << req_wcode;
   assign bad_req = (nbytes > ROW_BYTES) ||
                    ((int'(req_addr[OFF_W-1:0]) % nbytes) != 0);

   for (genvar k = 0; k < ROW_BYTES; k++) begin : g_mask
      assign fit_mask[k*8 +: 8] = (k < nbytes) ? 8'hFF : 8'h00;
   end

   always_ff @(posedge clk) fit_mask_q <= fit_mask;

   // R1: a response follows each request, and only a request
   a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R6: misaligned requests flag, aligned ones do not, error carries no data
   a_r6_misaligned_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && bad_req) |=> rsp_err);
   a_r6_aligned_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !bad_req) |=> !rsp_err);
   a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_data == '0));
   // R9: store responses carry zero data
   a_r9_store_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we) |=> (rsp_data == '0));
   // R3: a load never returns bits above its width
   a_r3_load_fits: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_we) |=> ((rsp_data & ~fit_mask_q) == '0));
endmodule

bind bytemem bm_chk #(.ROW_BYTES(ROW_BYTES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_bytemem.sv
module tb_bytemem;
   localparam int RB     = 8;
   localparam int DEPTH  = 16;
   localparam int ROW_W  = RB * 8;
   localparam int ADDR_W = $clog2(DEPTH) + $clog2(RB);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [1:0]        req_wcode = '0;
   logic              req_we = 1'b0;
   logic [ROW_W-1:0]  req_wdata = '0;
   logic              req_swap = 1'b0;
   logic              rsp_valid, rsp_err;
   logic [ROW_W-1:0]  rsp_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] model [DEPTH*RB];
   logic [ROW_W-1:0] q_data [$];
   logic             q_err  [$];
   string            q_tag  [$];

   bytemem #(.ROW_BYTES(RB), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wcode(req_wcode), .req_we(req_we), .req_wdata(req_wdata),
      .req_swap(req_swap), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_data(rsp_data)
   );

   always #5 clk = ~clk;

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // driver: present one request, push its expected response
   task automatic issue(input int addr, input int code, input bit we,
                        input logic [ROW_W-1:0] wd, input bit sw, input string tag);
      int nb, rem, base;
      logic [ROW_W-1:0] exp;
      bit mis;
      @(negedge clk);
      req_valid = 1'b1; req_addr = ADDR_W'(addr); req_wcode = 2'(code);
      req_we = we; req_wdata = wd; req_swap = sw;
      nb   = 1 << code;
      rem  = addr % RB;
      base = (addr / RB) * RB;
      mis  = (nb > RB) || ((rem % nb) != 0);
      exp  = '0;
      if (!mis) begin
         for (int i = 0; i < nb; i++) begin
            int src;
            src = sw ? (nb - 1 - i) : i;
            if (we) model[base + rem + i] = wd[src*8 +: 8];
         end
         if (!we) begin
            for (int i = 0; i < nb; i++) begin
               int dst;
               dst = sw ? (nb - 1 - i) : i;
               exp[dst*8 +: 8] = model[base + rem + i];
            end
         end
      end
      q_data.push_back(exp);
      q_err.push_back(mis);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; req_we = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (q_data.size() == 0) begin
            errors++;
            $display("FAIL R1: unexpected response data=%h err=%b expected no response",
                     rsp_data, rsp_err);
         end else begin
            logic [ROW_W-1:0] ed;
            logic ee;
            string t;
            ed = q_data.pop_front(); ee = q_err.pop_front(); t = q_tag.pop_front();
            if (rsp_data !== ed || rsp_err !== ee) begin
               errors++;
               $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                        t, rsp_data, rsp_err, ed, ee);
            end
         end
      end
   end

   initial begin
      #(20000 * 10);
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] lfsr;
      for (int i = 0; i < DEPTH*RB; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_data !== '0) begin
         errors++;
         $display("FAIL R2: reset outputs valid=%b err=%b data=%h expected 0 0 0",
                  rsp_valid, rsp_err, rsp_data);
      end

      issue(16'h10, 3, 0, '0, 0, "R2 unwritten row");
      issue(16'h08, 3, 1, 64'h1122334455667788, 0, "R5 full store");
      issue(16'h08, 3, 0, '0, 0, "R5 full load");
      issue(16'h0B, 0, 1, 64'h123456789ABCDEAA, 0, "R4 byte store");
      issue(16'h08, 3, 0, '0, 0, "R4 lanes kept");
      issue(16'h0E, 1, 0, '0, 0, "R1 half load at lane 6");
      issue(16'h09, 0, 0, '0, 0, "R3 byte load fits");
      issue(16'h14, 2, 1, 64'hFFFF0000A1B2C3D4, 1, "R7 swapped word store");
      issue(16'h14, 2, 0, '0, 0, "R7 word load plain");
      issue(16'h14, 2, 0, '0, 1, "R8 word load swapped");
      issue(16'h16, 1, 0, '0, 1, "R8 half load swapped");
      issue(16'h10, 3, 0, '0, 1, "R8 full row swapped");
      issue(16'h09, 1, 1, 64'hDEAD, 0, "R6 misaligned half store");
      issue(16'h08, 3, 0, '0, 0, "R6 row unchanged");
      issue(16'h0A, 2, 0, '0, 0, "R6 misaligned word load");
      issue(16'h0C, 3, 1, '1, 0, "R6 misaligned full store");
      issue(16'h08, 3, 0, '0, 0, "R6 row unchanged again");
      idle(2);
      issue(16'h78, 3, 1, 64'h0102030405060708, 0, "R9 store last row");
      issue(16'h7F, 0, 0, '0, 0, "R9 next-cycle load");
      issue(16'h7C, 2, 1, 64'hCAFEF00D, 0, "R4 upper word store");
      issue(16'h78, 3, 0, '0, 0, "R4 upper word merged");
      idle(1);

      lfsr = 32'h1ACE_B00C;
      for (int n = 0; n < 120; n++) begin
         int a, c;
         bit w, s;
         logic [ROW_W-1:0] d;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = int'(lfsr[ADDR_W-1:0]);
         c = int'(lfsr[9:8]);
         w = lfsr[12];
         s = lfsr[15];
         d = {lfsr, ~lfsr} ^ {32'(n), 32'(n * 7)};
         issue(a, c, w, d, s, w ? "R4 random store" : "R1 random load");
         if (lfsr[20]) idle(1);
      end
      for (int r = 0; r < DEPTH; r++) issue(r * RB, 3, 0, '0, 0, "R1 final row sweep");
      idle(3);
      checks++;
      if (q_data.size() != 0) begin
         errors++;
         $display("FAIL R1: pending responses=%0d expected 0", q_data.size());
      end
      finish_run();
   end
endmodule